// File: doc/BRIEF.md
# Serial Divide-by-Ten Unit

This block divides an unsigned binary operand by ten and returns both the quotient and the decimal remainder. It has no multiplier and no divider. Each clock performs one step: a conditional add-three correction on a four-bit decimal digit register, followed by a one-bit left rotation of the loop formed by the operand register and that digit register.

The operand register and the digit register form a ring. On every step, the operand's most significant bit moves into the low bit of the digit, and the corrected digit's top bit moves into the low bit of the operand. After as many steps as the operand is wide, every original operand bit has passed through the digit. The operand register then holds the quotient and the digit register holds the remainder.

A caller pulses `start` with the operand while the unit is idle. It then waits for the one-cycle `done` pulse and reads `quotient` and `remainder`, which hold their values until the next accepted start.

Top module: `div10_serial`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `quotient` and `remainder` are both 0.
- R2: When `start` is high at a clock edge while `busy` is 0, that edge loads `operand` into the working register and clears the digit. Directly after that edge, `busy` is 1 and `remainder` is 0.
- R3: Each operation takes exactly N clock edges after the loading edge, where N is the parameter `WIDTH` (default 10). `done` rises and `busy` falls after the N-th of those edges.
- R4: When `done` is high, `quotient` equals floor(operand / 10) of the accepted operand.
- R5: When `done` is high, `remainder` equals operand mod 10, encoded as an unsigned 4-bit value.
- R6: `remainder` never holds a value above 9 in any cycle, including mid-operation.
- R7: `done` is high for a single cycle for each operation.
- R8: A `start` pulse while `busy` is 1 is ignored. The running operation keeps its timing and its result, and the operand given with the ignored pulse has no effect.
- R9: While idle and without `start`, `quotient` and `remainder` keep their values.
- R10: With the default width, operand 1023 yields quotient 102 and remainder 3. Operands 0, 9, 10 and 1023 give exact results at these boundaries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to begin a division; accepted only while idle |
| operand | input | WIDTH | Unsigned dividend, sampled on the accepting edge |
| busy | output | 1 | High while the division steps are running |
| done | output | 1 | One-cycle pulse when the results are final |
| quotient | output | WIDTH | Dividend divided by ten, rounded down |
| remainder | output | 4 | Dividend modulo ten |

## Verification
Assertions check on every cycle that the digit stays a valid decimal value and that `done` lasts one cycle and coincides with the fall of `busy`. They also check that an accepted start clears the digit and raises `busy`, that `busy` persists while steps remain, and that idle outputs do not move. Only the bench scenarios can show that the arithmetic is correct for particular operands, that the pulse lands exactly N edges after acceptance, and that a start issued mid-operation leaves the running result and its timing unchanged.

// File: rtl/div10_pkg.sv
// Package: shared widths and types for the serial divide-by-ten unit.
// Assumes one decimal digit of four bits.
package div10_pkg;
    localparam int DIGIT_W = 4;
    localparam int DIGIT_MAX = 9;
    localparam int FIX_THRESHOLD = 5;
    localparam int FIX_ADDEND = 3;

    typedef logic [DIGIT_W-1:0] digit_t;
endpackage

// File: rtl/div10_digit_fix.sv
// Module: div10_digit_fix
// Applies the add-three correction to one decimal digit, so that doubling it
// afterwards carries into the next weight correctly.
// Assumes the input digit is a valid decimal value (0..9).
module div10_digit_fix
    import div10_pkg::*;
(
    input  digit_t digit_in,
    output digit_t digit_out
);
    // Purpose: add three when the digit is five or larger.
    always_comb begin
        if (digit_in >= digit_t'(FIX_THRESHOLD))
            digit_out = digit_in + digit_t'(FIX_ADDEND);
        else
            digit_out = digit_in;
    end
endmodule

// File: rtl/div10_rotate_step.sv
// Module: div10_rotate_step
// One combinational step of the loop: correct the digit, then rotate the
// {operand, digit} ring left by one bit. The operand MSB enters the digit LSB
// and the corrected digit MSB enters the operand LSB.
// Assumes WIDTH >= 2 and a valid decimal digit on input.
module div10_rotate_step
    import div10_pkg::*;
#(
    parameter int WIDTH = 10
) (
    input  logic [WIDTH-1:0] word_in,
    input  digit_t           digit_in,
    output logic [WIDTH-1:0] word_out,
    output digit_t           digit_out
);
    digit_t fixed;

    div10_digit_fix fix_i (
        .digit_in  (digit_in),
        .digit_out (fixed)
    );

    // Purpose: rotate the ring formed by the word and the corrected digit.
    always_comb begin
        word_out  = {word_in[WIDTH-2:0], fixed[DIGIT_W-1]};
        digit_out = {fixed[DIGIT_W-2:0], word_in[WIDTH-1]};
    end
endmodule

// File: rtl/div10_step_counter.sv
// Module: div10_step_counter
// Sequencer: counts the remaining steps, holds busy, and pulses done on the
// edge that executes the final step.
// Assumes load is only raised while idle.
module div10_step_counter #(
    parameter int STEPS = 10,
    localparam int CNT_W = $clog2(STEPS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy,
    output logic step_en,
    output logic done
);
    logic [CNT_W-1:0] remaining;
    logic             last_step;

    assign step_en   = busy;
    assign last_step = busy && (remaining == CNT_W'(1));

    // Purpose: track remaining steps and generate busy and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remaining <= '0;
            busy      <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= last_step;
            if (load) begin
                remaining <= CNT_W'(STEPS);
                busy      <= 1'b1;
            end else if (busy) begin
                remaining <= remaining - CNT_W'(1);
                if (last_step)
                    busy <= 1'b0;
            end
        end
    end

    // R3: busy stays high while more than one step remains
    a_r3_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && remaining > CNT_W'(1)) |=> busy);

    // R3: the done pulse coincides with the fall of busy
    a_r3_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
endmodule

// File: rtl/div10_serial.sv
// Module: div10_serial (top)
// Divides an unsigned WIDTH-bit operand by ten with one shift-and-correct
// step per clock. It returns the quotient in the working register and the
// remainder in the digit register after WIDTH steps.
// Assumes synchronous active-low reset. A start is accepted only while idle.
module div10_serial
    import div10_pkg::*;
#(
    parameter int WIDTH = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] operand,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] quotient,
    output logic [3:0]       remainder
);
    logic [WIDTH-1:0] word_q;
    logic [WIDTH-1:0] word_nxt;
    digit_t           digit_q;
    digit_t           digit_nxt;
    logic             accept;
    logic             step_en;

    assign accept = start && !busy;

    div10_step_counter #(
        .STEPS (WIDTH)
    ) seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .busy    (busy),
        .step_en (step_en),
        .done    (done)
    );

    div10_rotate_step #(
        .WIDTH (WIDTH)
    ) step_i (
        .word_in   (word_q),
        .digit_in  (digit_q),
        .word_out  (word_nxt),
        .digit_out (digit_nxt)
    );

    // Purpose: load the operand on accept, otherwise advance one step while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            digit_q <= '0;
        end else if (accept) begin
            word_q  <= operand;
            digit_q <= '0;
        end else if (step_en) begin
            word_q  <= word_nxt;
            digit_q <= digit_nxt;
        end
    end

    assign quotient  = word_q;
    assign remainder = digit_q;

    // R6: the digit register never leaves the decimal range
    a_r6_digit_decimal: assert property (@(posedge clk) disable iff (!rst_n)
        remainder <= 4'(DIGIT_MAX));

    // R2: an accepted start clears the digit and raises busy
    a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && remainder == 4'd0));

    // R7: done never lasts two cycles
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: idle outputs hold when no start arrives
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(quotient) && $stable(remainder)));
endmodule

// File: tb/div10_serial_tb_top.sv
`timescale 1ns/1ps
// Directed bench for div10_serial: one task per scenario, each checking its
// own results against values computed here from the requirements.
module div10_serial_tb_top;
    localparam int WIDTH = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [WIDTH-1:0] operand = '0;
    logic             busy;
    logic             done;
    logic [WIDTH-1:0] quotient;
    logic [3:0]       remainder;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    div10_serial #(.WIDTH(WIDTH)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .operand   (operand),
        .busy      (busy),
        .done      (done),
        .quotient  (quotient),
        .remainder (remainder)
    );

    task automatic check(input string req, input string what,
                         input longint actual, input longint expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
        end
    endtask

    // Launch one operation and check timing (R2, R3) and results (R4, R5).
    // When inject is set, a second start with other_op is pulsed mid-run (R8).
    task automatic run_div(input logic [WIDTH-1:0] v, input bit inject,
                           input logic [WIDTH-1:0] other_op);
        @(negedge clk);
        start   = 1'b1;
        operand = v;
        @(negedge clk);
        start   = 1'b0;
        operand = '0;
        check("R2", "busy after accept", busy, 1);
        check("R2", "digit cleared", remainder, 0);
        for (int i = 1; i <= WIDTH; i++) begin
            if (inject && i == 3) begin
                start   = 1'b1;
                operand = other_op;
            end else begin
                start   = 1'b0;
            end
            @(negedge clk);
            if (i < WIDTH) begin
                check("R3", "no early done", done, 0);
                if (inject) check("R8", "busy kept", busy, 1);
            end
        end
        start = 1'b0;
        check("R3", "done on step N", done, 1);
        check("R3", "busy dropped", busy, 0);
        check("R4", "quotient", quotient, v / 10);
        check("R5", "remainder", remainder, v % 10);
        @(negedge clk);
        check("R7", "done single cycle", done, 0);
    endtask

    task automatic test_reset();
        check("R1", "busy", busy, 0);
        check("R1", "done", done, 0);
        check("R1", "quotient", quotient, 0);
        check("R1", "remainder", remainder, 0);
    endtask

    task automatic test_worked_example();
        run_div(10'd1023, 0, '0);
        check("R10", "1023 quotient", quotient, 102);
        check("R10", "1023 remainder", remainder, 3);
    endtask

    task automatic test_boundaries();
        run_div(10'd0, 0, '0);
        check("R10", "zero quotient", quotient, 0);
        run_div(10'd9, 0, '0);
        check("R10", "nine remainder", remainder, 9);
        run_div(10'd10, 0, '0);
        check("R10", "ten quotient", quotient, 1);
        check("R10", "ten remainder", remainder, 0);
    endtask

    task automatic test_patterns();
        logic [WIDTH-1:0] lfsr = 10'h2A5;
        run_div(10'd999, 0, '0);
        run_div(10'd512, 0, '0);
        run_div(10'd37, 0, '0);
        for (int k = 0; k < 12; k++) begin
            lfsr = {lfsr[WIDTH-2:0], lfsr[9] ^ lfsr[6]};
            run_div(lfsr, 0, '0);
        end
    endtask

    task automatic test_start_while_busy();
        run_div(10'd777, 1, 10'd41);
    endtask

    task automatic test_idle_hold();
        logic [WIDTH-1:0] q0;
        logic [3:0]       r0;
        q0 = quotient;
        r0 = remainder;
        operand = 10'd555;
        repeat (5) @(negedge clk);
        check("R9", "quotient held", quotient, q0);
        check("R9", "remainder held", remainder, r0);
        check("R9", "still idle", busy, 0);
        operand = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_worked_example();
        test_boundaries();
        test_patterns();
        test_start_while_busy();
        test_idle_hold();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule